// File: doc/BRIEF.md
# Serial Flash Status Write and Sector Protection Unit

This block sits on the device side of a serial flash memory. It watches a four-wire serial bus (active-low select, serial clock, data in, data out) sampled in the core clock domain. It carries out three commands: set write enable, read status, and write status. A write-status frame that is accepted replaces the protection configuration held in the status byte. It then opens a self-timed busy window of fixed length, and the window is visible as a flag in that byte.

The protection configuration is a top/bottom select bit and a four-bit protect code. Together they name a range of low sectors that is read-only. The array controller presents each access on a request port (valid, write or read, sector number). The block raises a reject line for any program or erase request that falls inside the protected range. Reads are never rejected.

Top module: `sfp_top`

## Requirements
- R1: After reset the status byte is 0x00, the data-out enable is low, and no request is rejected.
- R2: A frame of exactly 8 bits carrying 0x06 sets the write-enable flag (status bit 1) when select rises.
- R3: A frame of exactly 16 bits, shifted MSB first, with opcode 0x01 followed by a data byte, loads the configuration when select rises. This happens only while write enable is set. Data bits 2..4 go to code bits 0..2 (status bits 2..4), data bit 5 goes to the top/bottom bit (status bit 5), and data bit 6 goes to code bit 3 (status bit 6). Data bits 0, 1 and 7 have no effect, and the frame does not itself change status bits 0 or 1.
- R4: A write-status frame that arrives while write enable is clear leaves the status byte unchanged and starts no busy window.
- R5: A frame whose length is not exactly the one its command needs (8 for write enable, 16 for write status) is discarded.
- R6: An accepted write-status frame sets the busy flag (status bit 0) in the cycle after select rises. The flag stays set for exactly BUSY_CYCLES core cycles. That count is limited to 8 ms at CLK_KHZ. When the flag clears, write enable clears in the same cycle.
- R7: While busy is set, write-enable and write-status frames are ignored, but read status still works.
- R8: After the 8 bits of opcode 0x05, the status byte present at the 8th rising serial-clock edge is driven MSB first on data out, one bit per following rising edge. The data-out enable is high from that edge until select rises.
- R9: With top/bottom = 1 and code c in 5..10, sectors 0 through 2^(c-1)-1 are protected, so that code 5 covers 0..15 and code 10 covers 0..511.
- R10: With top/bottom = 1 and code 11..15, all 1024 sectors are protected.
- R11: With top/bottom = 0, or with a code below 5, no sector is protected.
- R12: The reject output is high exactly when a valid write request names a protected sector. A read request is never rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock, sampled by clk |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (status byte) |
| spi_miso_en | output | 1 | Data-out drive enable |
| req_valid | input | 1 | Array access request present |
| req_write | input | 1 | Request is program/erase (1) or read (0) |
| req_sector | input | SECTOR_W | Target sector number |
| req_reject | output | 1 | Request refused by protection |
| stat_byte | output | 8 | Live status byte |

## Verification
The assertions assume that the bus inputs are synchronous to the core clock. They also assume that each serial-clock phase lasts at least one core cycle, and that select stays high for at least one cycle between frames. The cause-and-effect checks on select rising compare two earlier samples of select, and they rely on these assumptions. The bench drives every input on the falling core edge and holds each serial-clock phase for two cycles. It leaves idle cycles after every frame, so the sampled edges it produces are clean single-cycle events.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // Command codes (first byte of a frame, MSB first)
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  localparam int CMD_BITS  = 8;
  localparam int WRSR_BITS = 16;

  // Lowest protect code that covers any sector
  localparam logic [3:0] CODE_MIN = 4'd5;

  typedef struct packed {
    logic       tb;
    logic [3:0] code;
  } prot_cfg_t;

  // Busy length clamped to the 8 ms ceiling at the given clock rate
  function automatic int busy_len(input int req, input int khz);
    int lim;
    lim = 8 * khz;
    if (req < 1)   return 1;
    if (req > lim) return lim;
    return req;
  endfunction

  function automatic logic [7:0] pack_status(input prot_cfg_t c, input logic wel,
                                             input logic wip);
    return {1'b0, c.code[3], c.tb, c.code[2:0], wel, wip};
  endfunction

  function automatic prot_cfg_t unpack_cfg(input logic [7:0] b);
    prot_cfg_t c;
    c.tb   = b[5];
    c.code = {b[6], b[4:2]};
    return c;
  endfunction

endpackage

// File: rtl/sfp_spi_rx.sv
module sfp_spi_rx #(
  parameter int FRAME_W = 16,
  localparam int CW = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               mosi,
  output logic               sck_rise,
  output logic               frame_end,
  output logic [CW-1:0]      cnt_q,
  output logic [FRAME_W-1:0] shreg_q,
  output logic [FRAME_W-1:0] shreg_nx
);

  logic          cs_q, sck_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    sck_rise  = !cs_n && sck && !sck_q;
    frame_end = cs_n && !cs_q;
    shreg_nx  = {shreg_q[FRAME_W-2:0], mosi};
    cnt_d     = cnt_q;
    if (cs_n)
      cnt_d = '0;
    else if (sck_rise && (cnt_q != '1))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      cnt_q <= cnt_d;
      if (sck_rise)
        shreg_q <= shreg_nx;
    end
  end

endmodule

// File: rtl/sfp_status_ctrl.sv
module sfp_status_ctrl
  import sfp_pkg::*;
#(
  parameter int CW       = 5,
  parameter int BUSY_LEN = 1000,
  localparam int TW = (BUSY_LEN > 1) ? $clog2(BUSY_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sck_rise,
  input  logic                 frame_end,
  input  logic [CW-1:0]        cnt_q,
  input  logic [WRSR_BITS-1:0] shreg_q,
  input  logic [WRSR_BITS-1:0] shreg_nx,
  output prot_cfg_t            cfg_q,
  output logic                 wel_q,
  output logic                 wip_q,
  output logic                 miso,
  output logic                 miso_en
);

  prot_cfg_t   cfg_d;
  logic        wel_d, wip_d, rd_q, rd_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [7:0]  osh_q, osh_d;
  logic        is_wren, is_wrsr, is_rdsr;

  always_comb begin
    is_wren = (cnt_q == CW'(CMD_BITS))  && (shreg_q[7:0] == OP_WREN);
    is_wrsr = (cnt_q == CW'(WRSR_BITS)) && (shreg_q[15:8] == OP_WRSR);
    is_rdsr = (cnt_q == CW'(CMD_BITS - 1)) && (shreg_nx[7:0] == OP_RDSR);
  end

  always_comb begin
    cfg_d = cfg_q;
    wel_d = wel_q;
    wip_d = wip_q;
    tmr_d = tmr_q;
    rd_d  = rd_q;
    osh_d = osh_q;
    // self-timed window countdown
    if (wip_q) begin
      if (tmr_q == '0) begin
        wip_d = 1'b0;
        wel_d = 1'b0;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end
    // commands that act when select rises, only while idle
    if (frame_end && !wip_q) begin
      if (is_wren)
        wel_d = 1'b1;
      if (is_wrsr && wel_q) begin
        cfg_d = unpack_cfg(shreg_q[7:0]);
        wip_d = 1'b1;
        tmr_d = TW'(BUSY_LEN - 1);
      end
    end
    // status readout
    if (cs_n) begin
      rd_d = 1'b0;
    end else if (sck_rise) begin
      if (is_rdsr) begin
        rd_d  = 1'b1;
        osh_d = pack_status(cfg_q, wel_q, wip_q);
      end else if (rd_q) begin
        osh_d = {osh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wel_q <= 1'b0;
      wip_q <= 1'b0;
      tmr_q <= '0;
      rd_q  <= 1'b0;
      osh_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      wel_q <= wel_d;
      wip_q <= wip_d;
      tmr_q <= tmr_d;
      rd_q  <= rd_d;
      osh_q <= osh_d;
    end
  end

  assign miso    = osh_q[7];
  assign miso_en = rd_q;

endmodule

// File: rtl/sfp_prot_map.sv
module sfp_prot_map
  import sfp_pkg::*;
#(
  parameter int SECTOR_W = 10
) (
  input  prot_cfg_t           cfg,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [SECTOR_W-1:0] req_sector,
  output logic                req_reject
);

  logic [3:0] span_exp;
  logic       in_range;

  // protected span is 2^(code-1) low sectors, capped at the whole array
  always_comb begin
    span_exp = cfg.code - 4'd1;
    in_range = 1'b0;
    if (cfg.tb && (cfg.code >= CODE_MIN)) begin
      if (int'(span_exp) >= SECTOR_W)
        in_range = 1'b1;
      else
        in_range = ((req_sector >> span_exp) == '0);
    end
    req_reject = req_valid && req_write && in_range;
  end

endmodule

// File: rtl/sfp_top.sv
module sfp_top
  import sfp_pkg::*;
#(
  parameter int SECTOR_W    = 10,
  parameter int BUSY_CYCLES = 1000,
  parameter int CLK_KHZ     = 200000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_cs_n,
  input  logic                spi_sck,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_en,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [SECTOR_W-1:0] req_sector,
  output logic                req_reject,
  output logic [7:0]          stat_byte
);

  localparam int BUSY_LEN = busy_len(BUSY_CYCLES, CLK_KHZ);
  localparam int CW       = $clog2(WRSR_BITS + 2);

  logic                 sck_rise, frame_end, wel, wip;
  logic [CW-1:0]        cnt;
  logic [WRSR_BITS-1:0] shreg, shreg_nx;
  prot_cfg_t            cfg;

  sfp_spi_rx #(.FRAME_W(WRSR_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .sck_rise (sck_rise),
    .frame_end(frame_end),
    .cnt_q    (cnt),
    .shreg_q  (shreg),
    .shreg_nx (shreg_nx)
  );

  sfp_status_ctrl #(.CW(CW), .BUSY_LEN(BUSY_LEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n),
    .sck_rise (sck_rise),
    .frame_end(frame_end),
    .cnt_q    (cnt),
    .shreg_q  (shreg),
    .shreg_nx (shreg_nx),
    .cfg_q    (cfg),
    .wel_q    (wel),
    .wip_q    (wip),
    .miso     (spi_miso),
    .miso_en  (spi_miso_en)
  );

  sfp_prot_map #(.SECTOR_W(SECTOR_W)) u_map (
    .cfg       (cfg),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sector(req_sector),
    .req_reject(req_reject)
  );

  assign stat_byte = pack_status(cfg, wel, wip);

endmodule

// File: rtl/sfp_checker.sv
module sfp_checker
  import sfp_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000,
  parameter int CLK_KHZ     = 200000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso_en,
  input logic       req_valid,
  input logic       req_write,
  input logic       req_reject,
  input logic [7:0] stat_byte
);

  localparam int BUSY_LEN = busy_len(BUSY_CYCLES, CLK_KHZ);

  logic [1:0]  cyc;
  logic [31:0] run;
  logic [3:0]  code;

  assign code = {stat_byte[6], stat_byte[4:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 2'd0;
      run <= '0;
    end else begin
      if (cyc != 2'd2)
        cyc <= cyc + 2'd1;
      run <= stat_byte[0] ? run + 32'd1 : 32'd0;
    end
  end

  assert_wip_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_byte[0]) |-> (run == 32'(BUSY_LEN)));

  assert_wel_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_byte[0]) |-> !stat_byte[1]);

  assert_wip_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && $rose(stat_byte[0])) |-> ($past(spi_cs_n) && !$past(spi_cs_n, 2)));

  assert_wel_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[0] |-> stat_byte[1]);

  assert_cfg_at_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && stat_byte[6:2] != $past(stat_byte[6:2]))
      |-> ($past(spi_cs_n) && !$past(spi_cs_n, 2)));

  assert_miso_en_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_en) |-> !spi_cs_n);

  assert_all_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && stat_byte[5] && code >= 4'd11) |-> req_reject);

  assert_no_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!stat_byte[5] || code < CODE_MIN)) |-> !req_reject);

  assert_read_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_write) |-> !req_reject);

endmodule

bind sfp_top sfp_checker #(.BUSY_CYCLES(BUSY_CYCLES), .CLK_KHZ(CLK_KHZ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_cs_n   (spi_cs_n),
  .spi_miso_en(spi_miso_en),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_reject (req_reject),
  .stat_byte  (stat_byte)
);

// File: tb/tb_sfp_top.sv
`timescale 1ns/1ps
module tb_sfp_top;

  localparam int BUSY = 1000;
  localparam int SW   = 10;

  logic          clk = 1'b0;
  logic          rst_n, cs_n, sck, mosi, req_valid, req_write;
  logic [SW-1:0] req_sector;
  logic          miso, miso_en, req_reject;
  logic [7:0]    stat_byte;

  always #2.5 clk = ~clk;

  sfp_top #(.SECTOR_W(SW), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en), .req_valid(req_valid),
    .req_write(req_write), .req_sector(req_sector), .req_reject(req_reject),
    .stat_byte(stat_byte)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit cmp_en  = 0;
  int wip_run = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit q[$];
  int m_wel, m_wip, m_tb, m_code, m_rem, m_rd, m_cs_prev, m_sck_prev;

  function automatic logic [7:0] byte_of(input int off);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r = {r[6:0], q[off + i]};
    return r;
  endfunction

  function automatic logic [7:0] m_stat();
    logic [3:0] c = 4'(m_code);
    return {1'b0, c[3], 1'(m_tb), c[2:0], 1'(m_wel), 1'(m_wip)};
  endfunction

  function automatic int lim_of(input int tb, input int code);
    if (tb == 0 || code < 5) return 0;
    if (code >= 11) return 1024;
    return 1 << (code - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int ow, oe;
    logic [7:0] d;
    if (!rst_n) begin
      q.delete();
      m_wel = 0; m_wip = 0; m_tb = 0; m_code = 0; m_rem = 0; m_rd = 0;
      m_cs_prev = 1; m_sck_prev = 0;
    end else begin
      ow = m_wip; oe = m_wel;
      if (ow != 0) begin
        m_rem--;
        if (m_rem == 0) begin m_wip = 0; m_wel = 0; end
      end
      if (cs_n && m_cs_prev == 0 && ow == 0) begin
        if (q.size() == 8 && byte_of(0) == 8'h06) m_wel = 1;
        if (q.size() == 16 && byte_of(0) == 8'h01 && oe != 0) begin
          d = byte_of(8);
          m_tb = int'(d[5]); m_code = int'({d[6], d[4:2]});
          m_wip = 1; m_rem = BUSY;
        end
      end
      if (cs_n) begin
        q.delete(); m_rd = 0;
      end else if (sck && m_sck_prev == 0) begin
        q.push_back(mosi);
        if (q.size() == 8 && byte_of(0) == 8'h05) m_rd = 1;
      end
      m_cs_prev = int'(cs_n); m_sck_prev = int'(sck);
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_en) begin
      int lim;
      lim = lim_of(m_tb, m_code);
      check("R3/R6 model status", {24'd0, stat_byte}, {24'd0, m_stat()});
      check("R8 model miso_en", {31'd0, miso_en}, 32'(m_rd));
      check("R12 model reject", {31'd0, req_reject},
            32'(req_valid && req_write && (int'(req_sector) < lim)));
    end
  end

  always @(negedge clk) if (stat_byte[0] === 1'b1) wip_run++;

  // ---------------- stimulus tasks ----------------
  task automatic spi_xfer(input logic [15:0] v, input int n);
    @(negedge clk) cs_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i]; sck = 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    sck = 1'b0;
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic spi_rdsr(output logic [7:0] got, output logic en_ok);
    got = '0; en_ok = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      mosi = 8'h05 >> i; sck = 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      mosi = 1'b0; sck = 1'b0;
      repeat (2) @(negedge clk);
      got = {got[6:0], miso};
      if (miso_en !== 1'b1) en_ok = 1'b0;
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    sck = 1'b0;
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (stat_byte[0] === 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [7:0] got;
    logic       en_ok;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_sector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_write = 1'b1;
    @(negedge clk);
    check("R1 reset status", {24'd0, stat_byte}, 32'h00);
    check("R1 reset miso_en", {31'd0, miso_en}, 32'd0);
    check("R1 reset reject", {31'd0, req_reject}, 32'd0);
    req_valid = 1'b0; req_write = 1'b0;
    cmp_en = 1;

    // R4: write status without write enable
    spi_xfer(16'h017C, 16);
    check("R4 wrsr without wel", {24'd0, stat_byte}, 32'h00);

    // R5: wrong-length enable frames
    spi_xfer(16'h0003, 7);
    check("R5 short wren", {24'd0, stat_byte}, 32'h00);
    spi_xfer(16'h000C, 9);
    check("R5 long wren", {24'd0, stat_byte}, 32'h00);

    // R2: write enable
    spi_xfer(16'h0006, 8);
    check("R2 wren sets bit1", {24'd0, stat_byte}, 32'h02);

    // R5: truncated write status keeps wel, no busy
    spi_xfer(16'h00BE, 15);
    check("R5 short wrsr", {24'd0, stat_byte}, 32'h02);

    // R3/R6: full write status
    wip_run = 0;
    spi_xfer(16'h01FF, 16);
    check("R3 R6 busy status", {24'd0, stat_byte}, 32'h7F);

    // R7/R8: read status during busy
    spi_rdsr(got, en_ok);
    check("R8 R7 rdsr during busy", {24'd0, got}, 32'h7F);
    check("R8 miso_en during read", {31'd0, en_ok}, 32'd1);

    // R7: commands during busy ignored
    spi_xfer(16'h0006, 8);
    spi_xfer(16'h0100, 16);
    check("R7 wrsr ignored while busy", {24'd0, stat_byte}, 32'h7F);

    wait_idle();
    check("R6 busy length", 32'(wip_run), 32'(BUSY));
    check("R6 wel cleared at end", {24'd0, stat_byte}, 32'h7C);

    spi_rdsr(got, en_ok);
    check("R8 rdsr idle", {24'd0, got}, 32'h7C);

    // R3: data bits 0,1,7 have no effect
    spi_xfer(16'h0006, 8);
    spi_xfer(16'h0183, 16);
    check("R3 masked bits during busy", {24'd0, stat_byte}, 32'h03);
    wait_idle();
    check("R3 masked bits after", {24'd0, stat_byte}, 32'h00);

    // R9..R12: protection sweep
    for (int tb = 0; tb < 2; tb++) begin
      for (int code = 0; code < 16; code++) begin
        logic [3:0] c;
        logic [7:0] dbyte;
        int lim;
        int secs[6];
        string tag;
        c = 4'(code);
        dbyte = {1'b0, c[3], 1'(tb), c[2:0], 2'b00};
        spi_xfer(16'h0006, 8);
        spi_xfer({8'h01, dbyte}, 16);
        wait_idle();
        check("R3 cfg loaded", {24'd0, stat_byte}, {24'd0, dbyte});
        lim = lim_of(tb, code);
        if (tb == 0 || code < 5) tag = "R11 no protection";
        else if (code >= 11)    tag = "R10 full protection";
        else                    tag = "R9 doubling range";
        secs = '{0, (lim > 0) ? lim - 1 : 0, (lim < 1024) ? lim : 1023, 1023, 511, 16};
        foreach (secs[k]) begin
          req_valid = 1'b1; req_write = 1'b1; req_sector = SW'(secs[k]);
          #1;
          check(tag, {31'd0, req_reject}, 32'(secs[k] < lim));
          req_write = 1'b0;
          #1;
          check("R12 read never rejected", {31'd0, req_reject}, 32'd0);
          @(negedge clk);
        end
        req_valid = 1'b0;
      end
    end

    repeat (4) @(negedge clk);
    summary();
  end

endmodule